// File: doc/BRIEF.md
# I2C Register Target with Bus-Stuck Watchdog

This block is an I2C target that answers one 7-bit device address and gives an I2C controller access to a register window from 0x00 to 0x6B. The register storage sits outside the block. The block presents an address, write data and a one-cycle write strobe to that storage. It receives back the read data and a read-only flag for the location currently addressed.

After the address byte of a write frame, the first byte is a command byte that loads an internal pointer. Every data byte that gets an acknowledge moves the pointer on by one. It does not matter whether the target acknowledges the byte (a write) or the controller does (a read). Burst transfers therefore reach consecutive locations. A repeated START leaves the pointer where it is, so the usual "write the command, restart, read" sequence returns data from the commanded location.

SCL and SDA are sampled through two-flop synchronisers. The block drives the lines only through drive-low enables, in the open-drain style. A per-line watchdog counts system clocks while a line is low. When the count reaches a parametrised limit, the block drops its own drive and returns to idle. If the line is still low a further settle period later, the block raises a sleep request. The request stays high until both lines are seen high again.

Top module: `i2c_regmap_target`

## Requirements
- R1: After reset, sda_drive_low, scl_drive_low, reg_we and sleep_req are all 0.
- R2: An address byte whose upper seven bits equal DEV_ADDR is acknowledged (SDA held low in the ninth clock). A frame with any other address gets no acknowledge on any byte and causes no write until the next START or STOP.
- R3: The first byte after a write address is a command byte. A value of 0x6B or less is acknowledged and becomes the pointer. A value above 0x6B is not acknowledged, and the rest of the frame is ignored.
- R4: Each write data byte that is accepted is stored at the pointer through a single-cycle reg_we pulse and is acknowledged. The pointer then steps by one, so successive bytes land at successive locations.
- R5: A write data byte aimed at a location flagged read-only by reg_ro, or at a pointer above 0x6B, is not acknowledged and not stored. The rest of the frame is ignored.
- R6: In a read frame, bytes are sent MSB first, starting at the pointer. Each byte the controller acknowledges steps the pointer by one. A controller NACK ends the transfer without a step.
- R7: A repeated START does not change the pointer.
- R8: A read at a pointer above 0x6B returns 0xFF.
- R9: When SCL or SDA, after synchronisation, has been low for TIMEOUT_CYC consecutive clocks, sda_drive_low is forced to 0 and the engine returns to idle.
- R10: If that line is still low SETTLE_CYC clocks after the release, sleep_req goes to 1. It stays at 1 until that line is seen high again.
- R11: SCL is never driven low. SDA drive is switched on only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Level of the SCL line |
| sda_in | input | 1 | Level of the SDA line |
| scl_drive_low | output | 1 | Pull-down enable for SCL (always 0) |
| sda_drive_low | output | 1 | Pull-down enable for SDA |
| reg_addr | output | 8 | Register pointer presented to the storage |
| reg_wdata | output | 8 | Byte to store |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Contents of the location at reg_addr |
| reg_ro | input | 1 | Location at reg_addr is read-only |
| sleep_req | output | 1 | Low-power request after a stuck line |

## Verification
The situation hardest to reach from the ports is a timeout that happens while the target itself is pulling SDA low. In that case the release has to free SDA first, and the sleep request must then come from SCL alone. The bench gets there by clocking in a matching write address, letting the target assert its acknowledge, and then parking SCL low. A per-clock model of both line counters, which runs on the bus levels the bench observes, predicts the exact cycle of the release and of the sleep request.

// File: rtl/i2c_rt_pkg.sv
package i2c_rt_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_CMD,
      ST_CMD_ACK,
      ST_WDATA,
      ST_WDATA_ACK,
      ST_RDATA,
      ST_RDATA_ACK,
      ST_SKIP
   } eng_state_e;

   typedef struct packed {
      logic start;
      logic stop;
      logic rise;
      logic fall;
   } bus_evt_t;

endpackage

// File: rtl/i2c_rt_sync.sv
module i2c_rt_sync #(
   parameter int unsigned W      = 2,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk) begin
      if (!rst_n) stg <= '1;
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/i2c_rt_cond.sv
module i2c_rt_cond
   import i2c_rt_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     scl_s,
   input  logic     sda_s,
   output bus_evt_t evt
);
   logic scl_q, sda_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   always_comb begin
      evt.start = scl_s & scl_q & sda_q & ~sda_s;
      evt.stop  = scl_s & scl_q & ~sda_q & sda_s;
      evt.rise  = scl_s & ~scl_q;
      evt.fall  = ~scl_s & scl_q;
   end
endmodule

// File: rtl/i2c_rt_watchdog.sv
module i2c_rt_watchdog #(
   parameter int unsigned LINES       = 2,
   parameter int unsigned TIMEOUT_CYC = 200000,
   parameter int unsigned SETTLE_CYC  = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] line_s,
   output logic             release_o,
   output logic             sleep_o
);
   localparam int unsigned MAX_C = TIMEOUT_CYC + SETTLE_CYC;
   localparam int          CNT_W = $clog2(MAX_C + 1);
   localparam logic [CNT_W-1:0] TO_V  = CNT_W'(TIMEOUT_CYC);
   localparam logic [CNT_W-1:0] MAX_V = CNT_W'(MAX_C);

   logic [LINES-1:0] over, stuck;

   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic [CNT_W-1:0] cnt;
      always_ff @(posedge clk) begin
         if (!rst_n)            cnt <= '0;
         else if (line_s[g])    cnt <= '0;
         else if (cnt != MAX_V) cnt <= cnt + CNT_W'(1);
      end
      assign over[g]  = (cnt >= TO_V);
      assign stuck[g] = (cnt == MAX_V);
   end

   assign release_o = |over;
   assign sleep_o   = |stuck;
endmodule

// File: rtl/i2c_rt_engine.sv
module i2c_rt_engine
   import i2c_rt_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR  = 7'h55,
   parameter logic [7:0] LAST_ADDR = 8'h6B
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       abort,
   input  bus_evt_t   evt,
   input  logic       sda_s,
   input  logic [7:0] reg_rdata,
   input  logic       reg_ro,
   output logic       sda_low,
   output logic [7:0] ptr,
   output logic [7:0] sr,
   output logic       we
);
   eng_state_e state;
   logic [3:0] bitcnt;
   logic       rw;
   logic       mack;
   logic       bit8, wr_ok, cmd_ok;
   logic [7:0] rd_byte;

   assign bit8    = (bitcnt == 4'd8);
   assign wr_ok   = (ptr <= LAST_ADDR) && !reg_ro;
   assign cmd_ok  = (sr <= LAST_ADDR);
   assign rd_byte = (ptr <= LAST_ADDR) ? reg_rdata : 8'hFF;

   always_comb begin
      we = (state == ST_WDATA) && evt.fall && bit8 && wr_ok && !abort;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         bitcnt  <= '0;
         rw      <= 1'b0;
         mack    <= 1'b0;
         sda_low <= 1'b0;
         ptr     <= '0;
         sr      <= '0;
      end else if (abort) begin
         state   <= ST_IDLE;
         sda_low <= 1'b0;
      end else if (evt.start) begin
         state   <= ST_ADDR;
         bitcnt  <= '0;
         sda_low <= 1'b0;
      end else if (evt.stop) begin
         state   <= ST_IDLE;
         sda_low <= 1'b0;
      end else begin
         case (state)
            ST_ADDR, ST_CMD, ST_WDATA: begin
               if (evt.rise && !bit8) begin
                  sr     <= {sr[6:0], sda_s};
                  bitcnt <= bitcnt + 4'd1;
               end else if (evt.fall && bit8) begin
                  if (state == ST_ADDR) begin
                     if (sr[7:1] == DEV_ADDR) begin
                        rw      <= sr[0];
                        sda_low <= 1'b1;
                        state   <= ST_ADDR_ACK;
                     end else begin
                        state <= ST_SKIP;
                     end
                  end else if (state == ST_CMD) begin
                     if (cmd_ok) begin
                        ptr     <= sr;
                        sda_low <= 1'b1;
                        state   <= ST_CMD_ACK;
                     end else begin
                        state <= ST_SKIP;
                     end
                  end else begin
                     if (wr_ok) begin
                        ptr     <= ptr + 8'd1;
                        sda_low <= 1'b1;
                        state   <= ST_WDATA_ACK;
                     end else begin
                        state <= ST_SKIP;
                     end
                  end
               end
            end
            ST_ADDR_ACK: begin
               if (evt.fall) begin
                  bitcnt <= '0;
                  if (rw) begin
                     sr      <= rd_byte;
                     sda_low <= ~rd_byte[7];
                     state   <= ST_RDATA;
                  end else begin
                     sda_low <= 1'b0;
                     state   <= ST_CMD;
                  end
               end
            end
            ST_CMD_ACK, ST_WDATA_ACK: begin
               if (evt.fall) begin
                  sda_low <= 1'b0;
                  bitcnt  <= '0;
                  state   <= ST_WDATA;
               end
            end
            ST_RDATA: begin
               if (evt.rise && !bit8) begin
                  bitcnt <= bitcnt + 4'd1;
               end else if (evt.fall) begin
                  if (bit8) begin
                     sda_low <= 1'b0;
                     state   <= ST_RDATA_ACK;
                  end else begin
                     sda_low <= ~sr[6];
                     sr      <= {sr[6:0], 1'b1};
                  end
               end
            end
            ST_RDATA_ACK: begin
               if (evt.rise) begin
                  mack <= !sda_s;
                  if (!sda_s) ptr <= ptr + 8'd1;
               end else if (evt.fall) begin
                  if (mack) begin
                     sr      <= rd_byte;
                     sda_low <= ~rd_byte[7];
                     bitcnt  <= '0;
                     state   <= ST_RDATA;
                  end else begin
                     state <= ST_SKIP;
                  end
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/i2c_regmap_target.sv
module i2c_regmap_target
   import i2c_rt_pkg::*;
#(
   parameter logic [6:0]  DEV_ADDR    = 7'h55,
   parameter logic [7:0]  LAST_ADDR   = 8'h6B,
   parameter int unsigned TIMEOUT_CYC = 200000,
   parameter int unsigned SETTLE_CYC  = 64,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_in,
   input  logic       sda_in,
   output logic       scl_drive_low,
   output logic       sda_drive_low,
   output logic [7:0] reg_addr,
   output logic [7:0] reg_wdata,
   output logic       reg_we,
   input  logic [7:0] reg_rdata,
   input  logic       reg_ro,
   output logic       sleep_req
);
   localparam int unsigned N_LINES = 2;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (TIMEOUT_CYC == 0) begin : g_bad_timeout
      $error("TIMEOUT_CYC must be nonzero");
   end
   if (SETTLE_CYC <= SYNC_STAGES + 1) begin : g_bad_settle
      $error("SETTLE_CYC must exceed the synchroniser latency");
   end

   logic [N_LINES-1:0] lines_s;
   logic               scl_s, sda_s;
   bus_evt_t           evt;
   logic               wd_release;
   logic               eng_sda_low;

   i2c_rt_sync #(.W(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({scl_in, sda_in}),
      .q     (lines_s)
   );

   assign scl_s = lines_s[1];
   assign sda_s = lines_s[0];

   i2c_rt_cond u_cond (
      .clk   (clk),
      .rst_n (rst_n),
      .scl_s (scl_s),
      .sda_s (sda_s),
      .evt   (evt)
   );

   i2c_rt_watchdog #(
      .LINES       (N_LINES),
      .TIMEOUT_CYC (TIMEOUT_CYC),
      .SETTLE_CYC  (SETTLE_CYC)
   ) u_wd (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_s    (lines_s),
      .release_o (wd_release),
      .sleep_o   (sleep_req)
   );

   i2c_rt_engine #(.DEV_ADDR(DEV_ADDR), .LAST_ADDR(LAST_ADDR)) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .abort     (wd_release),
      .evt       (evt),
      .sda_s     (sda_s),
      .reg_rdata (reg_rdata),
      .reg_ro    (reg_ro),
      .sda_low   (eng_sda_low),
      .ptr       (reg_addr),
      .sr        (reg_wdata),
      .we        (reg_we)
   );

   assign sda_drive_low = eng_sda_low & ~wd_release;
   assign scl_drive_low = 1'b0;
endmodule

// File: rtl/i2c_regmap_target_chk.sv
module i2c_regmap_target_chk #(
   parameter logic [7:0] LAST_ADDR = 8'h6B
) (
   input logic       clk,
   input logic       rst_n,
   input logic       reg_we,
   input logic [7:0] reg_addr,
   input logic       reg_ro,
   input logic       sda_drive_low,
   input logic       sleep_req,
   input logic       scl_sync,
   input logic       sda_sync
);
   a_r5_we_only_writable: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> (reg_addr <= LAST_ADDR) && !reg_ro);

   a_r4_ptr_steps_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> reg_addr == $past(reg_addr) + 8'd1);

   a_r4_we_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we);

   a_r10_sleep_needs_low_line: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_req |-> $past(!scl_sync || !sda_sync));

   a_r9_no_drive_while_sleeping: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_req |-> !sda_drive_low);

   a_r11_sda_on_while_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_drive_low) |-> $past(!scl_sync));
endmodule

bind i2c_regmap_target i2c_regmap_target_chk #(.LAST_ADDR(LAST_ADDR)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .reg_we        (reg_we),
   .reg_addr      (reg_addr),
   .reg_ro        (reg_ro),
   .sda_drive_low (sda_drive_low),
   .sleep_req     (sleep_req),
   .scl_sync      (scl_s),
   .sda_sync      (sda_s)
);

// File: tb/i2c_regmap_target_test.sv
module i2c_regmap_target_test;
   localparam int CLK_PERIOD = 10;
   localparam int Q          = 6;
   localparam logic [6:0] DEV = 7'h3A;
   localparam int TO         = 400;
   localparam int ST         = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl_low = 1'b0;
   logic m_sda_low = 1'b0;
   logic scl_bus, sda_bus;
   logic scl_drive_low, sda_drive_low, reg_we, reg_ro, sleep_req;
   logic [7:0] reg_addr, reg_wdata, reg_rdata;
   logic [7:0] mem [0:255];
   logic [7:0] exp_mem [0:255];
   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign scl_bus = !(m_scl_low | scl_drive_low);
   assign sda_bus = !(m_sda_low | sda_drive_low);

   function automatic logic is_ro(logic [7:0] a);
      return (a[2:0] == 3'd5);
   endfunction

   assign reg_rdata = mem[reg_addr];
   assign reg_ro    = is_ro(reg_addr);

   always @(posedge clk) if (reg_we) mem[reg_addr] <= reg_wdata;

   i2c_regmap_target #(
      .DEV_ADDR(DEV), .LAST_ADDR(8'h6B), .TIMEOUT_CYC(TO), .SETTLE_CYC(ST), .SYNC_STAGES(2)
   ) uut (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_bus), .sda_in(sda_bus),
      .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
      .reg_rdata(reg_rdata), .reg_ro(reg_ro), .sleep_req(sleep_req)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Per-clock reference model of the two line-low counters
   int run_scl = 0, run_sda = 0;
   logic [2:0] ds = '0, dd = '0;
   always @(negedge clk) begin
      if (!rst_n) begin
         run_scl = 0; run_sda = 0; ds = '0; dd = '0;
      end else begin
         run_scl = ds[2] ? run_scl + 1 : 0;
         run_sda = dd[2] ? run_sda + 1 : 0;
         ds = {ds[1:0], !scl_bus};
         dd = {dd[1:0], !sda_bus};
         chk("R10 model sleep_req", 32'(sleep_req),
             32'((run_scl >= TO + ST) || (run_sda >= TO + ST)));
         if (run_scl >= TO || run_sda >= TO)
            chk("R9 model release", 32'(sda_drive_low), 32'd0);
         chk("R11 scl never driven", 32'(scl_drive_low), 32'd0);
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #(CLK_PERIOD/4);
   endtask

   task automatic start_c();
      m_sda_low = 0; m_scl_low = 0; step(Q);
      m_sda_low = 1; step(Q);
      m_scl_low = 1; step(Q);
   endtask

   task automatic restart_c();
      m_sda_low = 0; step(Q);
      m_scl_low = 0; step(Q);
      m_sda_low = 1; step(Q);
      m_scl_low = 1; step(Q);
   endtask

   task automatic stop_c();
      m_sda_low = 1; step(Q);
      m_scl_low = 0; step(Q);
      m_sda_low = 0; step(Q);
   endtask

   task automatic send_bits(input logic [7:0] b);
      for (int i = 7; i >= 0; i--) begin
         m_sda_low = !b[i]; step(Q);
         m_scl_low = 0; step(Q);
         m_scl_low = 1; step(Q);
      end
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      send_bits(b);
      m_sda_low = 0; step(Q);
      m_scl_low = 0; step(Q/2);
      ack = !sda_bus;
      step(Q/2);
      m_scl_low = 1; step(Q);
   endtask

   task automatic recv_byte(output logic [7:0] b, input logic do_ack);
      m_sda_low = 0;
      for (int i = 7; i >= 0; i--) begin
         step(Q);
         m_scl_low = 0; step(Q/2);
         b[i] = sda_bus;
         step(Q/2);
         m_scl_low = 1;
      end
      m_sda_low = do_ack; step(Q);
      m_scl_low = 0; step(Q);
      m_scl_low = 1; step(Q/2);
      m_sda_low = 0; step(Q/2);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic ack;
      logic [7:0] rd;
      for (int i = 0; i < 256; i++) begin
         mem[i] = 8'(i * 7 + 3);
         exp_mem[i] = 8'(i * 7 + 3);
      end
      step(5);
      chk("R1 sda_drive_low", 32'(sda_drive_low), 0);
      chk("R1 scl_drive_low", 32'(scl_drive_low), 0);
      chk("R1 reg_we", 32'(reg_we), 0);
      chk("R1 sleep_req", 32'(sleep_req), 0);
      rst_n = 1; step(10);

      // Two-byte burst write at 0x10
      start_c();
      send_byte({DEV, 1'b0}, ack); chk("R2 own address ack", 32'(ack), 1);
      send_byte(8'h10, ack);       chk("R3 command 0x10 ack", 32'(ack), 1);
      send_byte(8'h5C, ack);       chk("R4 data ack 0x10", 32'(ack), 1);
      send_byte(8'h7E, ack);       chk("R4 data ack 0x11", 32'(ack), 1);
      stop_c();
      exp_mem[8'h10] = 8'h5C; exp_mem[8'h11] = 8'h7E;
      chk("R4 stored 0x10", 32'(mem[8'h10]), 32'(exp_mem[8'h10]));
      chk("R4 stored 0x11", 32'(mem[8'h11]), 32'(exp_mem[8'h11]));

      // Command, repeated START, read back
      start_c();
      send_byte({DEV, 1'b0}, ack);
      send_byte(8'h10, ack);
      restart_c();
      send_byte({DEV, 1'b1}, ack); chk("R2 read address ack", 32'(ack), 1);
      recv_byte(rd, 1'b1);         chk("R7 read after restart", 32'(rd), 32'h5C);
      recv_byte(rd, 1'b0);         chk("R6 next byte after ack", 32'(rd), 32'h7E);
      stop_c();

      // Foreign address ignored
      start_c();
      send_byte({DEV ^ 7'h01, 1'b0}, ack); chk("R2 foreign address nack", 32'(ack), 0);
      send_byte(8'h20, ack);               chk("R2 foreign command nack", 32'(ack), 0);
      send_byte(8'h99, ack);               chk("R2 foreign data nack", 32'(ack), 0);
      stop_c();
      chk("R2 no write at 0x20", 32'(mem[8'h20]), 32'(exp_mem[8'h20]));

      // Command range
      start_c();
      send_byte({DEV, 1'b0}, ack);
      send_byte(8'h6C, ack); chk("R3 command 0x6C nack", 32'(ack), 0);
      stop_c();
      start_c();
      send_byte({DEV, 1'b0}, ack);
      send_byte(8'h6B, ack); chk("R3 command 0x6B ack", 32'(ack), 1);
      send_byte(8'h3C, ack); chk("R4 write at 0x6B ack", 32'(ack), 1);
      send_byte(8'h44, ack); chk("R5 write beyond 0x6B nack", 32'(ack), 0);
      stop_c();
      exp_mem[8'h6B] = 8'h3C;
      chk("R4 stored 0x6B", 32'(mem[8'h6B]), 32'h3C);
      chk("R5 no write at 0x6C", 32'(mem[8'h6C]), 32'(exp_mem[8'h6C]));

      // Read-only location
      start_c();
      send_byte({DEV, 1'b0}, ack);
      send_byte(8'h14, ack);
      send_byte(8'h11, ack); chk("R4 write 0x14 ack", 32'(ack), 1);
      send_byte(8'h22, ack); chk("R5 read-only 0x15 nack", 32'(ack), 0);
      stop_c();
      exp_mem[8'h14] = 8'h11;
      chk("R4 stored 0x14", 32'(mem[8'h14]), 32'h11);
      chk("R5 0x15 unchanged", 32'(mem[8'h15]), 32'(exp_mem[8'h15]));

      // Read across the end of the window
      start_c();
      send_byte({DEV, 1'b0}, ack);
      send_byte(8'h6B, ack);
      restart_c();
      send_byte({DEV, 1'b1}, ack);
      recv_byte(rd, 1'b1); chk("R6 read 0x6B", 32'(rd), 32'h3C);
      recv_byte(rd, 1'b0); chk("R8 read beyond window", 32'(rd), 32'hFF);
      stop_c();

      // Three-byte read from 0x00
      start_c();
      send_byte({DEV, 1'b0}, ack);
      send_byte(8'h00, ack);
      restart_c();
      send_byte({DEV, 1'b1}, ack);
      for (int k = 0; k < 3; k++) begin
         recv_byte(rd, k < 2);
         chk("R6 sequential read", 32'(rd), 32'(exp_mem[k]));
      end
      stop_c();

      // Timeout while the target holds its acknowledge, SCL parked low
      start_c();
      send_bits({DEV, 1'b0});
      m_sda_low = 0; step(Q);
      chk("R9 ack driven before timeout", 32'(sda_drive_low), 1);
      step(TO + ST + 10);
      chk("R9 drive released", 32'(sda_drive_low), 0);
      chk("R10 sleep with SCL stuck", 32'(sleep_req), 1);
      m_scl_low = 0; step(10);
      chk("R10 sleep cleared", 32'(sleep_req), 0);

      // SDA stuck low on its own
      m_sda_low = 1; step(TO + ST + 10);
      chk("R10 sleep with SDA stuck", 32'(sleep_req), 1);
      m_sda_low = 0; step(10);
      chk("R10 sleep cleared after SDA", 32'(sleep_req), 0);

      // Normal operation after recovery
      start_c();
      send_byte({DEV, 1'b0}, ack); chk("R9 recovered address ack", 32'(ack), 1);
      send_byte(8'h30, ack);
      send_byte(8'h9D, ack);
      restart_c();
      send_byte({DEV, 1'b1}, ack);
      recv_byte(rd, 1'b0); chk("R6 read at stepped pointer 0x31", 32'(rd), 32'(exp_mem[8'h31]));
      stop_c();
      exp_mem[8'h30] = 8'h9D;
      chk("R4 stored 0x30", 32'(mem[8'h30]), 32'h9D);

      step(10);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule